// File: doc/BRIEF.md
# Center-Aligned PWM Timer with Dead-Time Pair

This block is a triangle-wave PWM timer meant to drive the two switches of one half of an H-bridge. A 16-bit counter climbs from zero to a period value, turns, and descends back to zero, forever. Two working compare values place the edges of a complementary output pair. Output `pwm_a` works in toggle/reset style against compare A. Output `pwm_b` works in toggle/set style against compare B. When A is below B, the pair is never high together, and every hand-over holds B minus A timer clocks in which both outputs are low.

Software writes the period and the two compare values into shadow registers through a small write port. The three shadows move into the working latches in one clock, as a group. This happens either at the next count of zero, when `load_en` is held, or at once on a `load_now` pulse. Because the values move together, the two edges of the pair always come from one consistent set of values.

The counter can be retargeted mid-sweep by an immediate load. If the new period is at or above the live count, the sweep simply goes on up to it. If the new period is below the live count, the counter turns down after at most one more up-step. A sticky flag records each arrival at zero on the down slope, and one equality pulse per working latch marks each match.

Top module: `updown_pwm_dt`

## Requirements
- R1: While the period P is nonzero, `count` follows 0,1,…,P,P−1,…,1,0,1,… and changes by at most one per clock; a full sweep takes 2·P clocks.
- R2: While the working period is zero, `count` holds 0, no `eq` bit pulses, and the outputs keep their reset levels.
- R3: After a `load_now` that arrives while counting up, with a new period at or above the live count, the counter keeps climbing to the new period before turning down.
- R4: After a `load_now` that arrives while counting up, with a new period below the live count, the counter makes at most one further up-step and then counts down.
- R5: A write to a shadow register (`wr_addr` 0 = period, 1 = compare A, 2 = compare B) changes no output until a transfer occurs. Without `load_en` or `load_now`, there is no transfer at all.
- R6: With `load_en` high, all three shadows move into the working latches together on the clock where `count` is 0, and the next sweep uses all of the new values.
- R7: Once settled, `pwm_a` is high in a cycle exactly when the smaller of this cycle's and the previous cycle's `count` is below compare A (it toggles on a compare-A match and clears on a period match).
- R8: Once settled, `pwm_b` is high in a cycle exactly when the larger of this cycle's and the previous cycle's `count` is above compare B (it toggles on a compare-B match and sets on a period match).
- R9: With compare A below compare B, `pwm_a` and `pwm_b` are never high together, and each full sweep holds 2·(B−A) clocks with both low.
- R10: `eq[i]` is high for exactly the one cycle after `count` equals working latch i (0 = period, 1 = A, 2 = B), and only while the period is nonzero.
- R11: `zero_flag` rises in the cycle after `count` shows 0 reached by counting down. It stays high until a write to `wr_addr` 3, and a new arrival at zero in the same cycle as that write wins over the clear.
- R12: Synchronous reset gives `count` 0, `pwm_a` 1, `pwm_b` 0, `eq` 0, `zero_flag` 0, and all latches 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 period, 1 compare A, 2 compare B, 3 flag clear |
| wr_data | input | 16 | Value written to the addressed shadow |
| load_en | input | 1 | Allow group transfer at count zero |
| load_now | input | 1 | Group transfer on this clock |
| count | output | 16 | Live counter value |
| pwm_a | output | 1 | Toggle/reset output against compare A |
| pwm_b | output | 1 | Toggle/set output against compare B |
| eq | output | 3 | One-clock equality pulse per working latch |
| zero_flag | output | 1 | Sticky zero-reached flag |

## Verification
The bench builds the block with its default 16-bit counter and three latches. It uses small periods of 6, 10 and 12, so one up/down sweep lasts only tens of clocks and many sweeps fit in the run, including both load paths and both mid-sweep retarget cases. At these periods the dead-time window, the turn at the top and the flag-clear race at zero can all be hit on exact cycles chosen from the bench's own count prediction.

// File: rtl/pwm_dt_pkg.sv
`timescale 1ns/1ps
package pwm_dt_pkg;
  typedef enum logic {
    OUT_TOGGLE_RESET = 1'b0,
    OUT_TOGGLE_SET   = 1'b1
  } out_mode_e;

  localparam int IDX_PERIOD = 0;
  localparam int IDX_CMP_A  = 1;
  localparam int IDX_CMP_B  = 2;
endpackage

// File: rtl/pwm_dt_shadow.sv
`timescale 1ns/1ps
// Shadow registers plus working latches; all working latches load in one clock.
module pwm_dt_shadow #(
  parameter int W  = 16,
  parameter int N  = 3,
  parameter int AW = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [W-1:0]        wr_data,
  input  logic                xfer,
  output logic [N-1:0][W-1:0] lat
);
  logic [N-1:0][W-1:0] shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      lat    <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (wr_en && (wr_addr == AW'(i))) shadow[i] <= wr_data;
      end
      if (xfer) lat <= shadow;
    end
  end
endmodule

// File: rtl/pwm_dt_counter.sv
`timescale 1ns/1ps
// Triangle counter: climbs to per, turns, falls to zero; halts at zero when per is zero.
module pwm_dt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] per,
  output logic [W-1:0] cnt,
  output logic         dir_up
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else if (dir_up) begin
      if (cnt >= per) begin
        if (cnt != '0) begin
          cnt    <= cnt - ONE;
          dir_up <= 1'b0;
        end
      end else begin
        cnt <= cnt + ONE;
      end
    end else begin
      if (cnt == '0) begin
        dir_up <= 1'b1;
        if (per != '0) cnt <= ONE;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end
endmodule

// File: rtl/pwm_dt_out.sv
`timescale 1ns/1ps
// One output unit: toggle on own compare, force on period match.
module pwm_dt_out #(
  parameter int                    W       = 16,
  parameter pwm_dt_pkg::out_mode_e MODE    = pwm_dt_pkg::OUT_TOGGLE_RESET,
  parameter logic                  RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] per,
  output logic         q
);
  localparam logic FORCE_VAL = (MODE == pwm_dt_pkg::OUT_TOGGLE_SET);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else if (run) begin
      if (cnt == per)      q <= FORCE_VAL;
      else if (cnt == cmp) q <= ~q;
    end
  end
endmodule

// File: rtl/pwm_dt_match.sv
`timescale 1ns/1ps
// Registered equality pulse per working latch.
module pwm_dt_match #(
  parameter int W = 16,
  parameter int N = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic [W-1:0]        cnt,
  input  logic [N-1:0][W-1:0] lat,
  output logic [N-1:0]        eq
);
  for (genvar i = 0; i < N; i++) begin : g_eq
    always_ff @(posedge clk) begin
      if (rst) eq[i] <= 1'b0;
      else     eq[i] <= run && (cnt == lat[i]);
    end
  end
endmodule

// File: rtl/updown_pwm_dt.sv
`timescale 1ns/1ps
module updown_pwm_dt #(
  parameter int CNT_W   = 16,
  parameter int N_LATCH = 3,
  parameter int ADDR_W  = $clog2(N_LATCH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic               load_en,
  input  logic               load_now,
  output logic [CNT_W-1:0]   count,
  output logic               pwm_a,
  output logic               pwm_b,
  output logic [N_LATCH-1:0] eq,
  output logic               zero_flag
);
  import pwm_dt_pkg::*;

  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(N_LATCH);

  logic [N_LATCH-1:0][CNT_W-1:0] lat;
  logic                          dir_up;
  logic                          run;
  logic                          at_zero;
  logic                          zero_evt;
  logic                          xfer;
  logic [1:0]                    pwm_q;

  assign run      = (lat[IDX_PERIOD] != '0);
  assign at_zero  = (count == '0);
  assign zero_evt = at_zero && !dir_up;
  assign xfer     = (load_en && at_zero) || load_now;

  pwm_dt_shadow #(.W(CNT_W), .N(N_LATCH), .AW(ADDR_W)) u_shadow (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .xfer(xfer), .lat(lat)
  );

  pwm_dt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .per(lat[IDX_PERIOD]), .cnt(count), .dir_up(dir_up)
  );

  for (genvar j = 0; j < 2; j++) begin : g_out
    pwm_dt_out #(
      .W(CNT_W),
      .MODE((j == 0) ? OUT_TOGGLE_RESET : OUT_TOGGLE_SET),
      .RST_VAL((j == 0) ? 1'b1 : 1'b0)
    ) u_out (
      .clk(clk), .rst(rst), .run(run), .cnt(count),
      .cmp(lat[IDX_CMP_A + j]), .per(lat[IDX_PERIOD]), .q(pwm_q[j])
    );
  end

  assign pwm_a = pwm_q[0];
  assign pwm_b = pwm_q[1];

  pwm_dt_match #(.W(CNT_W), .N(N_LATCH)) u_match (
    .clk(clk), .rst(rst), .run(run), .cnt(count), .lat(lat), .eq(eq)
  );

  always_ff @(posedge clk) begin
    if (rst)                                  zero_flag <= 1'b0;
    else if (zero_evt)                        zero_flag <= 1'b1;
    else if (wr_en && (wr_addr == CLR_ADDR))  zero_flag <= 1'b0;
  end
endmodule

// File: rtl/pwm_dt_checker.sv
`timescale 1ns/1ps
module pwm_dt_checker #(
  parameter int W  = 16,
  parameter int N  = 3,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [W-1:0]  count,
  input logic          pwm_a,
  input logic          pwm_b,
  input logic [N-1:0]  eq,
  input logic          zero_flag,
  input logic          load_now,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [W-1:0]  per,
  input logic [W-1:0]  cmp_a,
  input logic [W-1:0]  cmp_b
);
  logic settled;

  always_ff @(posedge clk) begin
    if (rst)           settled <= 1'b0;
    else if (load_now) settled <= 1'b0;
    else if (eq[0])    settled <= 1'b1;
  end

  assert_step_one_R1: assert property (@(posedge clk) disable iff (rst)
    (count == $past(count)) || (count == $past(count) + W'(1)) || (count == $past(count) - W'(1)));

  assert_halt_R2: assert property (@(posedge clk) disable iff (rst)
    (per == '0 && $past(per) == '0 && $past(count) == '0) |-> (count == '0 && eq == '0));

  assert_top_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    (eq[0] && !$past(load_now)) |=> !eq[0]);

  assert_flag_on_zero_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(count) == W'(1) && count == '0) |=> zero_flag);

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (zero_flag && !(wr_en && wr_addr == AW'(N))) |=> zero_flag);

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
    (settled && cmp_a < cmp_b) |-> !(pwm_a && pwm_b));
endmodule

bind updown_pwm_dt pwm_dt_checker #(.W(CNT_W), .N(N_LATCH), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b),
  .eq(eq), .zero_flag(zero_flag), .load_now(load_now), .wr_en(wr_en),
  .wr_addr(wr_addr), .per(lat[0]), .cmp_a(lat[1]), .cmp_b(lat[2])
);

// File: tb/sim_updown_pwm_dt.sv
`timescale 1ns/1ps
module sim_updown_pwm_dt;
  localparam int W  = 16;
  localparam int N  = 3;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          wr_en    = 1'b0;
  logic [AW-1:0] wr_addr  = '0;
  logic [W-1:0]  wr_data  = '0;
  logic          load_en  = 1'b0;
  logic          load_now = 1'b0;
  logic [W-1:0]  count;
  logic          pwm_a, pwm_b, zero_flag;
  logic [N-1:0]  eq;

  updown_pwm_dt u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_en(load_en), .load_now(load_now), .count(count), .pwm_a(pwm_a),
    .pwm_b(pwm_b), .eq(eq), .zero_flag(zero_flag)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [W-1:0] cnt;
    logic [N-1:0] eq;
    logic         flag;
    logic         a;
    logic         b;
    bit           care;
  } exp_t;

  exp_t  q[$];
  string tq[$];

  logic [W-1:0] m_cnt = '0;
  bit           m_up  = 1'b1;
  logic [W-1:0] m_lat [N];
  logic [W-1:0] m_sh  [N];
  bit           m_flag = 1'b0;
  bit           m_settled = 1'b0;
  bit           m_ever = 1'b0;
  string        m_tag = "R1";

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // Driver: advance the expected-state model by one clock and queue the result.
  task automatic step();
    logic [W-1:0] prev, nc, lo, hi;
    bit nu, run, zevt;
    exp_t e;
    @(posedge clk);
    prev = m_cnt;
    run  = (m_lat[0] != '0);
    zevt = (m_cnt == '0) && !m_up;
    for (int i = 0; i < N; i++) e.eq[i] = run && (m_cnt == m_lat[i]);
    nc = m_cnt;
    nu = m_up;
    if (m_up) begin
      if (m_cnt >= m_lat[0]) begin
        if (m_cnt != '0) begin nc = m_cnt - W'(1); nu = 1'b0; end
      end else nc = m_cnt + W'(1);
    end else begin
      nu = 1'b1;
      if (m_cnt == '0) nc = run ? W'(1) : '0;
      else begin nc = m_cnt - W'(1); nu = 1'b0; end
    end
    if (e.eq[0]) m_settled = 1'b1;
    lo = (prev < nc) ? prev : nc;
    hi = (prev > nc) ? prev : nc;
    if (m_settled) begin
      e.care = 1'b1; e.a = (lo < m_lat[1]); e.b = (hi > m_lat[2]);
    end else if (!m_ever) begin
      e.care = 1'b1; e.a = 1'b1; e.b = 1'b0;
    end else begin
      e.care = 1'b0; e.a = 1'b0; e.b = 1'b0;
    end
    if (run) m_ever = 1'b1;
    if (zevt) m_flag = 1'b1;
    else if (wr_en && wr_addr == AW'(3)) m_flag = 1'b0;
    if ((load_en && m_cnt == '0) || load_now)
      for (int i = 0; i < N; i++) m_lat[i] = m_sh[i];
    if (wr_en && wr_addr < AW'(3)) m_sh[wr_addr] = wr_data;
    if (load_now) m_settled = 1'b0;
    m_cnt = nc;
    m_up  = nu;
    e.cnt  = m_cnt;
    e.flag = m_flag;
    #1;
    q.push_back(e);
    tq.push_back(m_tag);
    wr_en    = 1'b0;
    load_now = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
  endtask

  // Monitor: pop the expectation for this cycle and compare at the falling edge.
  initial begin
    exp_t  e;
    string t;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        t = tq.pop_front();
        chk(count == e.cnt, t, "count", int'(count), int'(e.cnt));
        chk(eq == e.eq, "R10", "eq", int'(eq), int'(e.eq));
        chk(zero_flag == e.flag, "R11", "zero_flag", int'(zero_flag), int'(e.flag));
        if (e.care) begin
          chk(pwm_a == e.a, "R7", "pwm_a", int'(pwm_a), int'(e.a));
          chk(pwm_b == e.b, "R8", "pwm_b", int'(pwm_b), int'(e.b));
          chk(!(pwm_a && pwm_b), "R9", "overlap", int'(pwm_a && pwm_b), 0);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int mx, both_low, n_eq1, c1, c2;
    for (int i = 0; i < N; i++) begin m_lat[i] = '0; m_sh[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R12: reset values
    chk(count == '0, "R12", "count", int'(count), 0);
    chk(pwm_a == 1'b1, "R12", "pwm_a", int'(pwm_a), 1);
    chk(pwm_b == 1'b0, "R12", "pwm_b", int'(pwm_b), 0);
    chk(eq == '0, "R12", "eq", int'(eq), 0);
    chk(zero_flag == 1'b0, "R12", "zero_flag", int'(zero_flag), 0);

    // R2: zero period keeps the counter parked
    m_tag = "R2";
    repeat (5) step();

    // R1: P=10, A=3, B=7, loaded at zero
    m_tag = "R1";
    wr(2'd0, 16'd10); wr(2'd1, 16'd3); wr(2'd2, 16'd7);
    load_en = 1'b1;
    mx = 0;
    for (int k = 0; k < 62; k++) begin
      step();
      if (int'(count) > mx) mx = int'(count);
    end
    chk(mx == 10, "R1", "peak count", mx, 10);
    chk(zero_flag == 1'b1, "R11", "flag after zero", int'(zero_flag), 1);

    // R11: clear away from zero, then clear racing an arrival at zero
    while (m_cnt != 16'd5) step();
    wr(2'd3, '0);
    chk(zero_flag == 1'b0, "R11", "flag cleared", int'(zero_flag), 0);
    while (!(m_cnt == '0 && !m_up)) step();
    wr(2'd3, '0);
    chk(zero_flag == 1'b1, "R11", "set beats clear", int'(zero_flag), 1);

    // R5: shadow writes without transfer leave timing untouched
    m_tag = "R5";
    load_en = 1'b0;
    while (!(m_cnt == 16'd2 && m_up)) step();
    wr(2'd0, 16'd6); wr(2'd1, 16'd2); wr(2'd2, 16'd4);
    mx = 0;
    for (int k = 0; k < 25; k++) begin
      step();
      if (int'(count) > mx) mx = int'(count);
    end
    chk(mx == 10, "R5", "peak with shadows pending", mx, 10);

    // R6: group transfer at zero, new period and compares together
    m_tag = "R6";
    load_en = 1'b1;
    while (m_lat[0] != 16'd6) step();
    mx = 0; both_low = 0; n_eq1 = 0;
    for (int k = 0; k < 24; k++) begin
      step();
      if (int'(count) > mx) mx = int'(count);
      if (!pwm_a && !pwm_b) both_low++;
      if (eq[1]) n_eq1++;
    end
    chk(mx == 6, "R6", "peak after group load", mx, 6);
    chk(n_eq1 == 4, "R6", "compare A pulses", n_eq1, 4);
    chk(both_low == 8, "R9", "dead clocks in two sweeps", both_low, 8);

    // R3: immediate load of a larger period while climbing
    m_tag = "R3";
    load_en = 1'b0;
    wr(2'd0, 16'd12);
    while (!(m_cnt == 16'd4 && m_up)) step();
    load_now = 1'b1;
    step();
    mx = 0;
    for (int k = 0; k < 20; k++) begin
      step();
      if (int'(count) > mx) mx = int'(count);
    end
    chk(mx == 12, "R3", "peak after raise", mx, 12);

    // R4: immediate load of a period below the live count while climbing
    m_tag = "R4";
    wr(2'd0, 16'd5);
    while (!(m_cnt == 16'd8 && m_up)) step();
    load_now = 1'b1;
    step();
    c1 = int'(count);
    step();
    c2 = int'(count);
    chk(c1 == 9, "R4", "extra up-step", c1, 9);
    chk(c2 == 8, "R4", "then down", c2, 8);
    repeat (20) step();

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule